// File: doc/BRIEF.md
# Read-Write Delay Region Monitor

This block watches the write and read address pointers of a field-delay memory and reports which kind of data a read is getting. The delay is how far the read pointer trails the write pointer, taken modulo the pointer wrap depth. A short delay means the read is still draining the previous field. A long delay, up to the capacity limit, means the read returns the field now being written. Anything in between, or past the capacity limit, gives undefined read data. Writes are still stored correctly in those windows.

On every active read cycle the monitor registers a 2-bit region code. It keeps a sticky flag that records any active read that fell in an undefined window after the pointers became trustworthy. It also follows the power-up rule for the pointers. Each port needs at least a minimum number of dummy active cycles and then a reset of its own. The pointers count as valid only once both ports have done this. The two ports may go through this sequence in the same period. Both pointers are assumed to be sampled in the single monitor clock domain.

Top module: `rw_delay_zone_mon`

## Requirements
- R1: The delay is (wr_ptr - rd_ptr) modulo DEPTH (default 524288). For example, wr_ptr=10 with rd_ptr=DEPTH-50 gives a delay of 60.
- R2: A delay of 0 to OLD_MAX (default 70) is classed as old-field data, region code 2'b00.
- R3: A delay from NEW_MIN to NEW_MAX (defaults 600 and 262214) is classed as new-field data, region code 2'b01.
- R4: Every other delay is classed as undefined, region code 2'b10. With the defaults this covers 71 to 599 and above 262214. Code 2'b11 never appears.
- R5: region takes the class of the delay at each rising edge where rd_act is high, and holds its value when rd_act is low.
- R6: undef_seen goes to 1 at a rising edge where rd_act is high, init_done is already 1 and the delay class is 2'b10. It then stays 1 until rst_n is asserted.
- R7: While init_done is 0, reads in an undefined window do not set undef_seen.
- R8: Each port counts edges where its active strobe is high and its reset input is low. A reset edge marks the port ready only if the count had reached DUMMY_MIN (default 80). Every reset edge clears the count, and a ready port stays ready.
- R9: init_done is 1 exactly when both ports are ready, whether their sequences ran one after the other or in the same cycles. It never falls until rst_n is asserted.
- R10: While rst_n is low, region is 2'b10 and undef_seen and init_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_ptr | input | PW (19) | Write address pointer |
| rd_ptr | input | PW (19) | Read address pointer |
| wr_rst | input | 1 | Write port reset event this cycle |
| rd_rst | input | 1 | Read port reset event this cycle |
| wr_act | input | 1 | Active write cycle strobe |
| rd_act | input | 1 | Active read cycle strobe |
| region | output | 2 | Delay class: 00 old, 01 new, 10 undefined |
| undef_seen | output | 1 | Sticky flag for an undefined read after initialization |
| init_done | output | 1 | Both pointers initialized |

## Verification
All three outputs are registered. Each one reflects the inputs sampled at a rising edge and is visible right after that edge. The bench drives inputs at the falling edge, waits one rising edge, updates its own model, and compares at the next falling edge. This way every check falls exactly one cycle after its stimulus. The delay boundaries at 70/71, 599/600 and 262214/262215 are driven directly, along with wrap-around and the 79-versus-80 dummy-cycle edge. Seeded random pointer pairs placed near those boundaries fill in the rest.

// File: rtl/rw_delay_zone_mon.sv
module rw_delay_zone_mon #(
  parameter int DEPTH     = 524288,
  parameter int OLD_MAX   = 70,
  parameter int NEW_MIN   = 600,
  parameter int NEW_MAX   = 262214,
  parameter int DUMMY_MIN = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  input  logic          wr_rst,
  input  logic          rd_rst,
  input  logic          wr_act,
  input  logic          rd_act,
  output logic [1:0]    region,
  output logic          undef_seen,
  output logic          init_done
);
  localparam int CW = $clog2(DUMMY_MIN + 1);
  localparam logic [PW:0]   DEPTH_V = DEPTH[PW:0];
  localparam logic [PW:0]   OLD_V   = OLD_MAX[PW:0];
  localparam logic [PW:0]   NMIN_V  = NEW_MIN[PW:0];
  localparam logic [PW:0]   NMAX_V  = NEW_MAX[PW:0];
  localparam logic [CW-1:0] DMIN_V  = DUMMY_MIN[CW-1:0];

  localparam logic [1:0] Z_OLD = 2'b00;
  localparam logic [1:0] Z_NEW = 2'b01;
  localparam logic [1:0] Z_UND = 2'b10;

  logic [PW:0] raw, dly;
  logic [1:0]  zone;
  logic [1:0]  p_act, p_rst, p_ok;

  assign raw = {1'b0, wr_ptr} - {1'b0, rd_ptr};
  assign dly = raw[PW] ? raw + DEPTH_V : raw;

  always_comb begin
    if (dly <= OLD_V)                      zone = Z_OLD;
    else if (dly >= NMIN_V && dly <= NMAX_V) zone = Z_NEW;
    else                                   zone = Z_UND;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region     <= Z_UND;
      undef_seen <= 1'b0;
    end else if (rd_act) begin
      region <= zone;
      if (init_done && zone == Z_UND) undef_seen <= 1'b1;
    end
  end

  assign p_act = {rd_act, wr_act};
  assign p_rst = {rd_rst, wr_rst};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt     <= '0;
        p_ok[p] <= 1'b0;
      end else if (p_rst[p]) begin
        if (cnt >= DMIN_V) p_ok[p] <= 1'b1;
        cnt <= '0;
      end else if (p_act[p] && cnt < DMIN_V) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign init_done = &p_ok;

  // R4
  region_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region != 2'b11);

  // R5
  region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> $stable(region));

  // R6
  undef_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_seen |=> undef_seen);

  // R6
  undef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undef_seen) |-> $past(rd_act));

  // R9
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  init_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(wr_rst || rd_rst));
endmodule

// File: tb/tb_rw_delay_zone_mon.sv
module tb_rw_delay_zone_mon;
  localparam int DEPTH = 524288;
  localparam int PW = 19;

  logic clk = 1'b0;
  logic rst_n;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic wr_rst, rd_rst, wr_act, rd_act;
  logic [1:0] region;
  logic undef_seen, init_done;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [1:0] exp_reg;
  logic exp_undef, exp_init;
  int cnt_w, cnt_r;
  bit ok_w, ok_r;

  always #5 clk = ~clk;

  rw_delay_zone_mon dut (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .wr_rst(wr_rst), .rd_rst(rd_rst), .wr_act(wr_act), .rd_act(rd_act),
    .region(region), .undef_seen(undef_seen), .init_done(init_done)
  );

  function automatic int delay_of(int w, int r);
    return (w - r + DEPTH) % DEPTH;
  endfunction

  function automatic logic [1:0] cls(int d);
    if (d <= 70) return 2'b00;
    if (d >= 600 && d <= 262214) return 2'b01;
    return 2'b10;
  endfunction

  function automatic string ztag(logic [1:0] z);
    if (z == 2'b00) return "R2";
    if (z == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    exp_reg = 2'b10; exp_undef = 0; exp_init = 0;
    cnt_w = 0; cnt_r = 0; ok_w = 0; ok_r = 0;
  endtask

  task automatic step(input int w, input int r, input bit wa, input bit ra,
                      input bit wrs, input bit rrs);
    logic [1:0] c;
    wr_ptr = w[PW-1:0]; rd_ptr = r[PW-1:0];
    wr_act = wa; rd_act = ra; wr_rst = wrs; rd_rst = rrs;
    @(posedge clk);
    c = cls(delay_of(w, r));
    if (ra) exp_reg = c;
    if (ra && exp_init && c == 2'b10) exp_undef = 1;
    if (wrs) begin if (cnt_w >= 80) ok_w = 1; cnt_w = 0; end
    else if (wa && cnt_w < 80) cnt_w++;
    if (rrs) begin if (cnt_r >= 80) ok_r = 1; cnt_r = 0; end
    else if (ra && cnt_r < 80) cnt_r++;
    exp_init = ok_w && ok_r;
    @(negedge clk);
    chk(ra ? ztag(exp_reg) : "R5", region, exp_reg);
    chk(exp_init ? "R6" : "R7", undef_seen, exp_undef);
    chk("R9", init_done, exp_init);
  endtask

  // read at a given delay (R1 wrap used when w < d)
  task automatic rd_at(input int w, input int d);
    step(w, (w - d + DEPTH) % DEPTH, 0, 1, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(1234);
    rst_n = 0; wr_ptr = 0; rd_ptr = 0;
    wr_rst = 0; rd_rst = 0; wr_act = 0; rd_act = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", region, 2'b10);
    chk("R10", undef_seen, 0);
    chk("R10", init_done, 0);
    rst_n = 1;

    // R7: undefined read before init leaves flag clear
    rd_at(1000, 300);
    chk("R7", undef_seen, 0);

    // R8: reset after only 79 write dummies does not count
    for (int i = 0; i < 79; i++) step(i, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 80; i++) step(i, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R8", init_done, 0);
    // R9: both ports together, 80 cycles each, reset in same cycle
    for (int i = 0; i < 80; i++) step(i, i, 1, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    chk("R9", init_done, 1);
    // reset cycle must not be counted as a dummy cycle
    step(0, 0, 0, 0, 1, 1);
    chk("R9", init_done, 1);

    // boundaries (R2 R3 R4)
    rd_at(5000, 0);      chk("R2", region, 2'b00);
    rd_at(5000, 70);     chk("R2", region, 2'b00);
    rd_at(5000, 71);     chk("R4", region, 2'b10);
    chk("R6", undef_seen, 1);
    rd_at(5000, 20);     chk("R6", undef_seen, 1);
    rd_at(5000, 599);    chk("R4", region, 2'b10);
    rd_at(5000, 600);    chk("R3", region, 2'b01);
    rd_at(300000, 262214); chk("R3", region, 2'b01);
    rd_at(300000, 262215); chk("R4", region, 2'b10);
    // R1 wrap-around
    step(10, DEPTH - 50, 0, 1, 0, 0);  chk("R1", region, 2'b00);
    step(5, DEPTH - 100, 0, 1, 0, 0);  chk("R1", region, 2'b10);
    step(400, DEPTH - 400, 0, 1, 0, 0); chk("R1", region, 2'b01);
    // R5 hold when rd_act low
    step(1000, 0, 1, 0, 0, 0); chk("R5", region, 2'b01);

    // R6/R7 after system reset: flag clears, init lost
    rst_n = 0; @(posedge clk); model_reset(); @(negedge clk);
    chk("R10", undef_seen, 0);
    chk("R10", init_done, 0);
    rst_n = 1;

    // random: init partway, reads near boundaries
    for (int n = 0; n < 3000; n++) begin
      int w, d, pick;
      bit wa, ra, wrs, rrs;
      w = int'($urandom % DEPTH);
      pick = int'($urandom % 10);
      case (pick)
        0: d = int'($urandom % 71);
        1: d = 71 + int'($urandom % 529);
        2: d = 598 + int'($urandom % 4);
        3: d = 262212 + int'($urandom % 4);
        4: d = 68 + int'($urandom % 5);
        default: d = int'($urandom % DEPTH);
      endcase
      wa = ($urandom % 4) != 0;
      ra = ($urandom % 3) != 0;
      wrs = (n > 500) && ($urandom % 150) == 0;
      rrs = (n > 500) && ($urandom % 150) == 0;
      step(w, (w - d + DEPTH) % DEPTH, wa, ra, wrs, rrs);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule